// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block is the execute stage of a 64-bit integer pipeline, built as pure combinational logic. It receives an operation code that the decoder has already resolved, the two source register values, the immediate already sign-extended to 64 bits, the destination register index and the program counter of the instruction. From these it produces the data to write back with its write enable, a control-transfer flag with the next program counter, and the effective address for a memory access.

The datapath covers the 64-bit arithmetic, logic, compare and shift operations in register and immediate forms. It also covers the 32-bit "word" variants, whose results are sign-extended to 64 bits, the six conditional branches, the two jumps with their link value, and the two upper-immediate operations. For the upper-immediate operations the decoder supplies the immediate with its low 12 bits already zero. Memory access itself, register storage and atomics are handled by other blocks. The load, store and fence codes only produce an address here, or nothing at all.

Top module: `exu_top`

## Requirements
- R1: Operation codes on `op_i` are: 0 LUI, 1 AUIPC, 2 JAL, 3 JALR, 4 BEQ, 5 BNE, 6 BLT, 7 BGE, 8 BLTU, 9 BGEU, 10 ADD, 11 SUB, 12 SLL, 13 SLT, 14 SLTU, 15 XOR, 16 SRL, 17 SRA, 18 OR, 19 AND, 20 ADDI, 21 SLTI, 22 SLTIU, 23 XORI, 24 SLLI, 25 SRLI, 26 SRAI, 27 ORI, 28 ANDI, 29 ADDW, 30 SUBW, 31 SLLW, 32 SRLW, 33 SRAW, 34 ADDIW, 35 SLLIW, 36 SRLIW, 37 SRAIW, 38 LOAD, 39 STORE, 40 FENCE. Immediate forms use `imm_i` in place of `rs2_val_i`.
- R2: When `rd_idx_i` is 0, `rd_we_o` is 0. Whenever `rd_we_o` is 0, `rd_wdata_o` is all zeros.
- R3: LUI writes `imm_i`. AUIPC writes `pc_i + imm_i`.
- R4: JAL and JALR write `pc_i + 4` and raise `taken_o`. The JAL target is `pc_i + imm_i`. The JALR target is `rs1_val_i + imm_i` with bit 0 cleared.
- R5: A branch raises `taken_o` when its condition holds and then sets `next_pc_o = pc_i + imm_i`. BLT and BGE compare as signed, BLTU and BGEU as unsigned. Whenever `taken_o` is 0, `next_pc_o = pc_i + 4`.
- R6: ADD, SUB, XOR, OR, AND and their immediate forms produce the full 64-bit result, with wrap-around on overflow.
- R7: SLT, SLTU, SLTI and SLTIU write 1 when the first operand is less than the second (signed or unsigned as named) and 0 otherwise, with bits 63:1 zero.
- R8: 64-bit shifts take their amount from bits 5:0 of the second operand. SLL shifts left, SRL shifts right with zero fill, and SRA shifts right copying bit 63.
- R9: Word operations use only bits 31:0 of their operands and write the 32-bit result sign-extended from bit 31. Word shifts take their amount from bits 4:0. ADDIW adds `imm_i[31:0]` to `rs1_val_i[31:0]`.
- R10: `mem_addr_o` equals `rs1_val_i + imm_i`. LOAD, STORE, FENCE and the branches never raise `rd_we_o`.
- R11: Codes 41 to 63 write nothing, leave `taken_o` at 0 and give `next_pc_o = pc_i + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Resolved operation code (R1) |
| rd_idx_i | input | REG_AW (5) | Destination register index |
| rs1_val_i | input | XLEN (64) | First source value |
| rs2_val_i | input | XLEN (64) | Second source value |
| imm_i | input | XLEN (64) | Sign-extended immediate |
| pc_i | input | XLEN (64) | Address of the instruction |
| rd_wdata_o | output | XLEN (64) | Write-back data, zero when not writing |
| rd_we_o | output | 1 | Write-back enable |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | XLEN (64) | Address of the next instruction |
| mem_addr_o | output | XLEN (64) | Load/store effective address |

## Verification
The bench builds the unit with XLEN at 64 and REG_AW at 5, the defaults. At these values the 32-bit word half is a real subset of the datapath, so sign extension from bit 31 and the 5-bit against 6-bit shift-amount split can both be observed. Operands that carry stray high bits in the shift amount, signed and unsigned boundary values such as the most negative number, odd jump targets and undefined codes are driven both as directed cases and from a pseudo-random mix.

// File: rtl/exu_pkg.sv
// Package: shared operation codes for the integer execute unit.
// Assumes the decoder resolves each instruction to one of these codes.
package exu_pkg;
    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        XOP_LUI    = 6'd0,  XOP_AUIPC  = 6'd1,
        XOP_JAL    = 6'd2,  XOP_JALR   = 6'd3,
        XOP_BEQ    = 6'd4,  XOP_BNE    = 6'd5,
        XOP_BLT    = 6'd6,  XOP_BGE    = 6'd7,
        XOP_BLTU   = 6'd8,  XOP_BGEU   = 6'd9,
        XOP_ADD    = 6'd10, XOP_SUB    = 6'd11,
        XOP_SLL    = 6'd12, XOP_SLT    = 6'd13,
        XOP_SLTU   = 6'd14, XOP_XOR    = 6'd15,
        XOP_SRL    = 6'd16, XOP_SRA    = 6'd17,
        XOP_OR     = 6'd18, XOP_AND    = 6'd19,
        XOP_ADDI   = 6'd20, XOP_SLTI   = 6'd21,
        XOP_SLTIU  = 6'd22, XOP_XORI   = 6'd23,
        XOP_SLLI   = 6'd24, XOP_SRLI   = 6'd25,
        XOP_SRAI   = 6'd26, XOP_ORI    = 6'd27,
        XOP_ANDI   = 6'd28, XOP_ADDW   = 6'd29,
        XOP_SUBW   = 6'd30, XOP_SLLW   = 6'd31,
        XOP_SRLW   = 6'd32, XOP_SRAW   = 6'd33,
        XOP_ADDIW  = 6'd34, XOP_SLLIW  = 6'd35,
        XOP_SRLIW  = 6'd36, XOP_SRAIW  = 6'd37,
        XOP_LOAD   = 6'd38, XOP_STORE  = 6'd39,
        XOP_FENCE  = 6'd40
    } exu_op_e;

    // Basic operation performed by a shared arithmetic unit.
    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_SLL, FN_SLT, FN_SLTU,
        FN_XOR, FN_SRL, FN_SRA, FN_OR, FN_AND, FN_NONE
    } alu_fn_e;
endpackage

// File: rtl/exu_alu.sv
// Module: full-width arithmetic/logic unit.
// Performs one basic function on two XLEN operands. Shift amounts use
// the low log2(XLEN) bits of operand b. Assumes XLEN is a power of two.
module exu_alu #(
    parameter int XLEN = 64
) (
    input  exu_pkg::alu_fn_e  fn_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic [XLEN-1:0]   res_o
);
    import exu_pkg::*;

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]    shamt;
    logic [2*XLEN-1:0] a_ext;
    logic [XLEN-1:0]   sra_res;

    assign shamt = b_i[SHW-1:0];
    assign a_ext = {{XLEN{a_i[XLEN-1]}}, a_i};
    // Arithmetic right shift: widen with sign copies, shift logically, keep low half.
    assign sra_res = XLEN'(a_ext >> shamt);

    // Select the requested function.
    always_comb begin
        unique case (fn_i)
            FN_ADD:  res_o = a_i + b_i;
            FN_SUB:  res_o = a_i - b_i;
            FN_SLL:  res_o = a_i << shamt;
            FN_SLT:  res_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            FN_SLTU: res_o = {{(XLEN-1){1'b0}}, a_i < b_i};
            FN_XOR:  res_o = a_i ^ b_i;
            FN_SRL:  res_o = a_i >> shamt;
            FN_SRA:  res_o = sra_res;
            FN_OR:   res_o = a_i | b_i;
            FN_AND:  res_o = a_i & b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/exu_alu_word.sv
// Module: half-width (word) arithmetic unit.
// Operates on HW-bit operands and returns the result sign-extended to
// XLEN bits. Only add, subtract and the three shifts are meaningful.
module exu_alu_word #(
    parameter int XLEN = 64
) (
    input  exu_pkg::alu_fn_e    fn_i,
    input  logic [XLEN/2-1:0]   a_i,
    input  logic [XLEN/2-1:0]   b_i,
    output logic [XLEN-1:0]     res_o
);
    import exu_pkg::*;

    localparam int HW  = XLEN / 2;
    localparam int SHW = $clog2(HW);

    logic [SHW-1:0]  shamt;
    logic [2*HW-1:0] a_ext;
    logic [HW-1:0]   word;

    assign shamt = b_i[SHW-1:0];
    assign a_ext = {{HW{a_i[HW-1]}}, a_i};

    // Compute the narrow result.
    always_comb begin
        unique case (fn_i)
            FN_ADD:  word = a_i + b_i;
            FN_SUB:  word = a_i - b_i;
            FN_SLL:  word = a_i << shamt;
            FN_SRL:  word = a_i >> shamt;
            FN_SRA:  word = HW'(a_ext >> shamt);
            default: word = '0;
        endcase
    end

    // Sign-extend the narrow result from its top bit.
    assign res_o = {{(XLEN-HW){word[HW-1]}}, word};
endmodule

// File: rtl/exu_branch.sv
// Module: control-transfer resolution.
// Evaluates branch conditions and forms jump/branch targets. Assumes imm_i
// is already sign-extended and a multiple of two for branches and JAL.
module exu_branch #(
    parameter int XLEN = 64
) (
    input  exu_pkg::exu_op_e op_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [XLEN-1:0]  rs2_i,
    input  logic [XLEN-1:0]  imm_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic             taken_o,
    output logic [XLEN-1:0]  target_o
);
    import exu_pkg::*;

    logic            eq;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] pc_rel;
    logic [XLEN-1:0] reg_rel;

    assign eq      = (rs1_i == rs2_i);
    assign lt_s    = $signed(rs1_i) < $signed(rs2_i);
    assign lt_u    = rs1_i < rs2_i;
    assign pc_rel  = pc_i + imm_i;
    assign reg_rel = rs1_i + imm_i;

    // Decide whether control transfers and where to.
    always_comb begin
        target_o = pc_rel;
        unique case (op_i)
            XOP_JAL:  taken_o = 1'b1;
            XOP_JALR: begin
                taken_o  = 1'b1;
                target_o = {reg_rel[XLEN-1:1], 1'b0};
            end
            XOP_BEQ:  taken_o = eq;
            XOP_BNE:  taken_o = !eq;
            XOP_BLT:  taken_o = lt_s;
            XOP_BGE:  taken_o = !lt_s;
            XOP_BLTU: taken_o = lt_u;
            XOP_BGEU: taken_o = !lt_u;
            default:  taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exu_top.sv
// Module: integer execute unit, combinational.
// Takes a resolved operation with its operands and produces write-back
// data, the next PC and the memory address. Holds no state; the register
// file and memory live elsewhere. Writes to register 0 are suppressed.
module exu_top #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5
) (
    input  logic [exu_pkg::OP_W-1:0] op_i,
    input  logic [REG_AW-1:0]        rd_idx_i,
    input  logic [XLEN-1:0]          rs1_val_i,
    input  logic [XLEN-1:0]          rs2_val_i,
    input  logic [XLEN-1:0]          imm_i,
    input  logic [XLEN-1:0]          pc_i,
    output logic [XLEN-1:0]          rd_wdata_o,
    output logic                     rd_we_o,
    output logic                     taken_o,
    output logic [XLEN-1:0]          next_pc_o,
    output logic [XLEN-1:0]          mem_addr_o
);
    import exu_pkg::*;

    localparam int HW = XLEN / 2;
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    typedef enum logic [2:0] {
        SRC_NONE, SRC_IMM, SRC_PCIMM, SRC_LINK, SRC_FULL, SRC_WORD
    } wb_src_e;

    exu_op_e         op;
    alu_fn_e         fn;
    logic            use_imm;
    wb_src_e         src;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] full_res;
    logic [XLEN-1:0] word_res;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_target;
    logic            br_taken;
    logic [XLEN-1:0] wb_val;
    logic            wants_write;

    assign op     = exu_op_e'(op_i);
    assign seq_pc = pc_i + INSN_BYTES;

    // Map each operation to a basic function, operand source and write source.
    always_comb begin
        fn      = FN_NONE;
        use_imm = 1'b0;
        src     = SRC_NONE;
        unique case (op)
            XOP_LUI:   src = SRC_IMM;
            XOP_AUIPC: src = SRC_PCIMM;
            XOP_JAL, XOP_JALR: src = SRC_LINK;
            XOP_ADD:   begin fn = FN_ADD;  src = SRC_FULL; end
            XOP_SUB:   begin fn = FN_SUB;  src = SRC_FULL; end
            XOP_SLL:   begin fn = FN_SLL;  src = SRC_FULL; end
            XOP_SLT:   begin fn = FN_SLT;  src = SRC_FULL; end
            XOP_SLTU:  begin fn = FN_SLTU; src = SRC_FULL; end
            XOP_XOR:   begin fn = FN_XOR;  src = SRC_FULL; end
            XOP_SRL:   begin fn = FN_SRL;  src = SRC_FULL; end
            XOP_SRA:   begin fn = FN_SRA;  src = SRC_FULL; end
            XOP_OR:    begin fn = FN_OR;   src = SRC_FULL; end
            XOP_AND:   begin fn = FN_AND;  src = SRC_FULL; end
            XOP_ADDI:  begin fn = FN_ADD;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_SLTI:  begin fn = FN_SLT;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_SLTIU: begin fn = FN_SLTU; src = SRC_FULL; use_imm = 1'b1; end
            XOP_XORI:  begin fn = FN_XOR;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_SLLI:  begin fn = FN_SLL;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_SRLI:  begin fn = FN_SRL;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_SRAI:  begin fn = FN_SRA;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_ORI:   begin fn = FN_OR;   src = SRC_FULL; use_imm = 1'b1; end
            XOP_ANDI:  begin fn = FN_AND;  src = SRC_FULL; use_imm = 1'b1; end
            XOP_ADDW:  begin fn = FN_ADD;  src = SRC_WORD; end
            XOP_SUBW:  begin fn = FN_SUB;  src = SRC_WORD; end
            XOP_SLLW:  begin fn = FN_SLL;  src = SRC_WORD; end
            XOP_SRLW:  begin fn = FN_SRL;  src = SRC_WORD; end
            XOP_SRAW:  begin fn = FN_SRA;  src = SRC_WORD; end
            XOP_ADDIW: begin fn = FN_ADD;  src = SRC_WORD; use_imm = 1'b1; end
            XOP_SLLIW: begin fn = FN_SLL;  src = SRC_WORD; use_imm = 1'b1; end
            XOP_SRLIW: begin fn = FN_SRL;  src = SRC_WORD; use_imm = 1'b1; end
            XOP_SRAIW: begin fn = FN_SRA;  src = SRC_WORD; use_imm = 1'b1; end
            default:   src = SRC_NONE;
        endcase
    end

    assign opnd_b = use_imm ? imm_i : rs2_val_i;

    exu_alu #(.XLEN(XLEN)) u_alu (
        .fn_i  (fn),
        .a_i   (rs1_val_i),
        .b_i   (opnd_b),
        .res_o (full_res)
    );

    exu_alu_word #(.XLEN(XLEN)) u_alu_word (
        .fn_i  (fn),
        .a_i   (rs1_val_i[HW-1:0]),
        .b_i   (opnd_b[HW-1:0]),
        .res_o (word_res)
    );

    exu_branch #(.XLEN(XLEN)) u_branch (
        .op_i     (op),
        .rs1_i    (rs1_val_i),
        .rs2_i    (rs2_val_i),
        .imm_i    (imm_i),
        .pc_i     (pc_i),
        .taken_o  (br_taken),
        .target_o (br_target)
    );

    // Pick the write-back value from its source.
    always_comb begin
        unique case (src)
            SRC_IMM:   wb_val = imm_i;
            SRC_PCIMM: wb_val = pc_i + imm_i;
            SRC_LINK:  wb_val = seq_pc;
            SRC_FULL:  wb_val = full_res;
            SRC_WORD:  wb_val = word_res;
            default:   wb_val = '0;
        endcase
    end

    assign wants_write = (src != SRC_NONE);
    assign rd_we_o     = wants_write && (rd_idx_i != '0);
    assign rd_wdata_o  = rd_we_o ? wb_val : '0;
    assign taken_o     = br_taken;
    assign next_pc_o   = br_taken ? br_target : seq_pc;
    assign mem_addr_o  = rs1_val_i + imm_i;
endmodule

// File: rtl/exu_checker.sv
// Module: property checker for exu_top, attached by bind.
// All checks are immediate, since the unit is combinational.
module exu_checker #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5
) (
    input logic [exu_pkg::OP_W-1:0] op_i,
    input logic [REG_AW-1:0]        rd_idx_i,
    input logic [XLEN-1:0]          rs1_val_i,
    input logic [XLEN-1:0]          rs2_val_i,
    input logic [XLEN-1:0]          imm_i,
    input logic [XLEN-1:0]          pc_i,
    input logic [XLEN-1:0]          rd_wdata_o,
    input logic                     rd_we_o,
    input logic                     taken_o,
    input logic [XLEN-1:0]          next_pc_o,
    input logic [XLEN-1:0]          mem_addr_o
);
    import exu_pkg::*;

    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    logic is_jump;
    logic is_slt;
    logic is_word;
    logic no_wb;

    assign is_jump = (op_i == XOP_JAL) || (op_i == XOP_JALR);
    assign is_slt  = (op_i == XOP_SLT) || (op_i == XOP_SLTU) ||
                     (op_i == XOP_SLTI) || (op_i == XOP_SLTIU);
    assign is_word = (op_i >= XOP_ADDW) && (op_i <= XOP_SRAIW);
    assign no_wb   = (op_i >= XOP_BEQ && op_i <= XOP_BGEU) ||
                     (op_i >= XOP_LOAD);

    // Check output relations for the present inputs.
    always_comb begin
        p_x0_silent_r2: assert ((rd_idx_i != '0) || !rd_we_o);
        p_idle_zero_r2: assert (rd_we_o || (rd_wdata_o == '0));
        p_link_value_r4: assert (!(is_jump && rd_idx_i != '0) ||
                                 (rd_we_o && rd_wdata_o == pc_i + FOUR));
        p_jalr_even_r4: assert ((op_i != XOP_JALR) ||
                                (taken_o && !next_pc_o[0]));
        p_beq_equal_r5: assert ((op_i != XOP_BEQ) ||
                                (taken_o == (rs1_val_i == rs2_val_i)));
        p_seq_pc_r5: assert (taken_o || (next_pc_o == pc_i + FOUR));
        p_slt_bool_r7: assert (!is_slt || (rd_wdata_o[XLEN-1:1] == '0));
        p_word_sext_r9: assert (!is_word ||
                                (rd_wdata_o[XLEN-1:XLEN/2] ==
                                 {(XLEN/2){rd_wdata_o[XLEN/2-1]}}));
        p_addr_sum_r10: assert (mem_addr_o == rs1_val_i + imm_i);
        p_no_wb_r10: assert (!no_wb || !rd_we_o);
    end
endmodule

bind exu_top exu_checker #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
    .op_i       (op_i),
    .rd_idx_i   (rd_idx_i),
    .rs1_val_i  (rs1_val_i),
    .rs2_val_i  (rs2_val_i),
    .imm_i      (imm_i),
    .pc_i       (pc_i),
    .rd_wdata_o (rd_wdata_o),
    .rd_we_o    (rd_we_o),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/sim_exu_top.sv
// Bench for exu_top: behavioural reference model compared every clock.
module sim_exu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op;
    logic [4:0]  rd;
    logic [63:0] a, b, imm, pc;
    logic [63:0] wd, np, ma;
    logic        we, tk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    exu_top u0 (
        .op_i(op), .rd_idx_i(rd), .rs1_val_i(a), .rs2_val_i(b),
        .imm_i(imm), .pc_i(pc), .rd_wdata_o(wd), .rd_we_o(we),
        .taken_o(tk), .next_pc_o(np), .mem_addr_o(ma)
    );

    // Requirement tag for an operation code (codes per R1).
    function automatic string tag_of(input logic [5:0] o, input logic [4:0] r);
        if (r == 0 && (o <= 3 || (o >= 10 && o <= 37))) return "R2";
        if (o <= 1)  return "R3";
        if (o <= 3)  return "R4";
        if (o <= 9)  return "R5";
        if (o == 13 || o == 14 || o == 21 || o == 22) return "R7";
        if (o == 12 || o == 16 || o == 17 || o == 24 || o == 25 || o == 26) return "R8";
        if (o <= 28) return "R6";
        if (o <= 37) return "R9";
        if (o <= 40) return "R10";
        return "R11";
    endfunction

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Apply one vector, wait to mid-cycle, compare against the model.
    task automatic run(input logic [5:0] o, input logic [4:0] r,
                       input logic [63:0] va, input logic [63:0] vb,
                       input logic [63:0] vi, input logic [63:0] vp);
        logic [63:0] res, tgt, e_wd, e_np;
        logic [31:0] w;
        bit wr, e_we, e_tk;
        string t;
        @(posedge clk);
        #1;
        op = o; rd = r; a = va; b = vb; imm = vi; pc = vp;
        @(negedge clk);
        res = 0; wr = 1; e_tk = 0; tgt = vp + vi;
        case (o)
            0:  res = vi;
            1:  res = vp + vi;
            2:  begin res = vp + 4; e_tk = 1; end
            3:  begin res = vp + 4; e_tk = 1; tgt = (va + vi) & ~64'd1; end
            4:  begin wr = 0; e_tk = (va == vb); end
            5:  begin wr = 0; e_tk = (va != vb); end
            6:  begin wr = 0; e_tk = ($signed(va) < $signed(vb)); end
            7:  begin wr = 0; e_tk = ($signed(va) >= $signed(vb)); end
            8:  begin wr = 0; e_tk = (va < vb); end
            9:  begin wr = 0; e_tk = (va >= vb); end
            10: res = va + vb;
            11: res = va - vb;
            12: res = va << vb[5:0];
            13: res = ($signed(va) < $signed(vb)) ? 64'd1 : 64'd0;
            14: res = (va < vb) ? 64'd1 : 64'd0;
            15: res = va ^ vb;
            16: res = va >> vb[5:0];
            17: res = $signed(va) >>> vb[5:0];
            18: res = va | vb;
            19: res = va & vb;
            20: res = va + vi;
            21: res = ($signed(va) < $signed(vi)) ? 64'd1 : 64'd0;
            22: res = (va < vi) ? 64'd1 : 64'd0;
            23: res = va ^ vi;
            24: res = va << vi[5:0];
            25: res = va >> vi[5:0];
            26: res = $signed(va) >>> vi[5:0];
            27: res = va | vi;
            28: res = va & vi;
            29: begin w = va[31:0] + vb[31:0]; res = sx32(w); end
            30: begin w = va[31:0] - vb[31:0]; res = sx32(w); end
            31: begin w = va[31:0] << vb[4:0]; res = sx32(w); end
            32: begin w = va[31:0] >> vb[4:0]; res = sx32(w); end
            33: begin w = $signed(va[31:0]) >>> vb[4:0]; res = sx32(w); end
            34: begin w = va[31:0] + vi[31:0]; res = sx32(w); end
            35: begin w = va[31:0] << vi[4:0]; res = sx32(w); end
            36: begin w = va[31:0] >> vi[4:0]; res = sx32(w); end
            37: begin w = $signed(va[31:0]) >>> vi[4:0]; res = sx32(w); end
            default: wr = 0;
        endcase
        e_we = wr && (r != 0);
        e_wd = e_we ? res : 64'd0;
        e_np = e_tk ? tgt : vp + 4;
        t = tag_of(o, r);
        n_chk++;
        if (we !== e_we || wd !== e_wd || tk !== e_tk || np !== e_np ||
            ma !== va + vi) begin
            n_fail++;
            $display("FAIL %s op=%0d: we/wd/tk/np/ma = %0b/%h/%0b/%h/%h expected %0b/%h/%0b/%h/%h",
                     t, o, we, wd, tk, np, ma, e_we, e_wd, e_tk, e_np, va + vi);
        end
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 5))
            0: return 64'd0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h0000_0000_7FFF_FFFF;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        op = 6'd63; rd = 0; a = 0; b = 0; imm = 0; pc = 64'h1000;
        // Reset state: an undefined code writes nothing (R11).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (we !== 1'b0 || tk !== 1'b0 || np !== 64'h1004 || wd !== 64'd0) begin
            n_fail++;
            $display("FAIL R11 reset: we=%0b tk=%0b np=%h expected 0 0 1004", we, tk, np);
        end
        rst_n = 1'b1;

        // Directed corners; codes follow the R1 table.
        run(10, 0, 64'd5, 64'd6, 0, 64'h100);                        // R2 write to x0
        run(0, 5, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'h200);           // R3 LUI
        run(1, 5, 0, 0, 64'h0000_0000_0001_2000, 64'h200);           // R3 AUIPC
        run(2, 1, 0, 0, -64'sd8, 64'h400);                           // R4 JAL back
        run(3, 1, 64'h1001, 0, 64'd4, 64'h400);                      // R4 JALR odd target
        run(6, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd16, 64'h500);  // R5 BLT signed taken
        run(8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd16, 64'h500);  // R5 BLTU not taken
        run(9, 0, 64'd7, 64'd7, 64'd32, 64'h500);                    // R5 BGEU equal
        run(11, 3, 64'd0, 64'd1, 0, 0);                              // R6 SUB wrap
        run(13, 3, 64'h8000_0000_0000_0000, 64'd0, 0, 0);            // R7 SLT most negative
        run(22, 3, 64'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);            // R7 SLTIU vs all-ones
        run(12, 4, 64'd3, 64'h41, 0, 0);                             // R8 SLL amount 65 -> 1
        run(17, 4, 64'h8000_0000_0000_0000, 64'd63, 0, 0);           // R8 SRA full shift
        run(34, 6, 64'h0000_0000_7FFF_FFFF, 0, 64'd1, 0);            // R9 ADDIW overflow
        run(33, 6, 64'h0000_0000_8000_0000, 64'h3F, 0, 0);           // R9 SRAW amount 31
        run(31, 6, 64'hFFFF_FFFF_0000_0001, 64'd31, 0, 0);           // R9 SLLW into bit 31
        run(39, 7, 64'h2000, 64'd9, -64'sd4, 0);                     // R10 STORE address
        run(38, 7, 64'h2000, 0, 64'd12, 0);                          // R10 LOAD no write
        run(40, 7, 0, 0, 0, 64'h600);                                // R10 FENCE
        run(45, 7, 1, 2, 3, 64'h700);                                // R11 undefined code

        // Pseudo-random mix over all codes, including undefined ones.
        for (int i = 0; i < 4000; i++) begin
            run(6'($urandom_range(0, 45)), 5'($urandom_range(0, 31)),
                pick(), pick(), pick(), {$urandom(), $urandom()});
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule